// File: doc/BRIEF.md
# Masked Accept/Reject Frame Filter

This block decides, for every received frame, whether the frame goes into the receive queue or is dropped. For each frame it takes an identifier, the index of the receive channel the frame came in on, and a one-cycle valid strobe. It compares the identifier against two masked patterns. The first pattern admits frames. The second pattern drops frames. Each pattern has its own set of enabled channels.

A host programs five configuration words through a simple write port: an accept pattern, an accept mask, a drop pattern, a drop mask, and a channel-enable word. A mask bit set to 1 excludes that identifier bit from the comparison. The verdict is registered. It appears with a valid pulse one clock after the frame strobe.

Identifier extraction and the queue storage are outside this block.

Top module: `ff_frame_filter`

## Requirements
- R1: A frame matches the accept pattern when every identifier bit with a 0 in the accept mask equals the same bit of the accept pattern. A frame on an accept-enabled channel that matches and is not dropped gives dec_store = 1.
- R2: An accept mask bit of 1 makes that identifier bit don't-care. Identifiers that differ from the accept pattern only in masked bits are still stored.
- R3: A frame that matches the drop pattern on a drop-enabled channel gives dec_store = 0, even when it also matches the accept pattern.
- R4: A drop mask bit of 1 makes that identifier bit don't-care for the drop comparison. A difference in any unmasked bit prevents the drop.
- R5: A frame whose channel is not enabled for acceptance is never stored. Bit k of the channel word (bits NUM_CH-1..0) enables acceptance on channel k.
- R6: A drop only applies on channels enabled for dropping. Bit NUM_CH+k of the channel word enables dropping on channel k. A drop match on a channel that is not enabled for dropping does not block the store.
- R7: dec_valid is high in the cycle after each cycle in which frm_valid is high, and low otherwise. dec_store is 0 whenever dec_valid is 0.
- R8: A configuration write takes effect for frames presented from the cycle after the write. A frame presented in the same cycle as a write is judged with the old settings.
- R9: Synchronous active-high reset clears all five configuration words and dec_valid. After reset no frame is stored until acceptance channels are enabled.
- R10: The write select codes are: 0 accept pattern, 1 accept mask, 2 drop pattern, 3 drop mask, 4 channel word. A write with select 5, 6 or 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_sel | input | 3 | Configuration word select (R10 encoding) |
| cfg_wr_data | input | ID_W (11) | Configuration write data |
| frm_valid | input | 1 | Frame present this cycle |
| frm_id | input | ID_W (11) | Frame identifier |
| frm_chan | input | CH_W (1) | Receive channel index |
| dec_valid | output | 1 | Verdict present (one cycle after frm_valid) |
| dec_store | output | 1 | 1 = store frame, 0 = discard |

## Verification
The bench tries exact-match identifiers and identifiers that differ by one bit. This separates a working comparison from a stuck one. It then uses identifiers that differ only inside the mask and identifiers that differ just outside it, which exposes a mask applied with the wrong polarity or to the wrong bits.

Some frames match both patterns, to show that dropping takes priority. The same identifiers are then sent on each channel under different enable words, which separates the two enable fields. A write issued in the same cycle as a frame, writes with unused select codes, and a long random mixed stream each show, against a behavioural model, whether a setting took effect too early or was changed by mistake.

// File: rtl/ff_pkg.sv
package ff_pkg;

    localparam int FF_ID_W   = 11;
    localparam int FF_NUM_CH = 2;

    typedef enum logic [2:0] {
        SEL_ACC_PAT  = 3'd0,
        SEL_ACC_MASK = 3'd1,
        SEL_DRP_PAT  = 3'd2,
        SEL_DRP_MASK = 3'd3,
        SEL_CHAN     = 3'd4
    } cfg_sel_e;

    typedef struct packed {
        logic valid;
        logic store;
    } verdict_t;

    function automatic logic fold_verdict(input logic acc_hit, input logic drp_hit);
        return acc_hit && !drp_hit;
    endfunction

endpackage

// File: rtl/ff_cfg_regs.sv
module ff_cfg_regs
    import ff_pkg::*;
#(
    parameter int ID_W   = FF_ID_W,
    parameter int NUM_CH = FF_NUM_CH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [ID_W-1:0]   wr_data,
    output logic [ID_W-1:0]   acc_pat,
    output logic [ID_W-1:0]   acc_mask,
    output logic [ID_W-1:0]   drp_pat,
    output logic [ID_W-1:0]   drp_mask,
    output logic [NUM_CH-1:0] acc_chen,
    output logic [NUM_CH-1:0] drp_chen
);
    localparam int CHW_BITS = 2 * NUM_CH;

    logic [CHW_BITS-1:0] chan_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_pat   <= '0;
            acc_mask  <= '0;
            drp_pat   <= '0;
            drp_mask  <= '0;
            chan_word <= '0;
        end else if (wr_en) begin
            case (cfg_sel_e'(wr_sel))
                SEL_ACC_PAT:  acc_pat   <= wr_data;
                SEL_ACC_MASK: acc_mask  <= wr_data;
                SEL_DRP_PAT:  drp_pat   <= wr_data;
                SEL_DRP_MASK: drp_mask  <= wr_data;
                SEL_CHAN:     chan_word <= wr_data[CHW_BITS-1:0];
                default: ;
            endcase
        end
    end

    assign acc_chen = chan_word[NUM_CH-1:0];
    assign drp_chen = chan_word[CHW_BITS-1:NUM_CH];

endmodule

// File: rtl/ff_masked_match.sv
module ff_masked_match
    import ff_pkg::*;
#(
    parameter int ID_W   = FF_ID_W,
    parameter int NUM_CH = FF_NUM_CH,
    parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [ID_W-1:0]   id,
    input  logic [CH_W-1:0]   chan,
    input  logic [ID_W-1:0]   pat,
    input  logic [ID_W-1:0]   mask,
    input  logic [NUM_CH-1:0] chen,
    output logic              hit
);
    logic [NUM_CH-1:0] chan_dec;
    logic [ID_W-1:0]   diff;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        assign chan_dec[g] = (chan == CH_W'(g));
    end

    assign diff = (id ^ pat) & ~mask;
    assign hit  = (|(chan_dec & chen)) && (diff == '0);

endmodule

// File: rtl/ff_verdict.sv
module ff_verdict
    import ff_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic frm_valid,
    input  logic acc_hit,
    input  logic drp_hit,
    output logic dec_valid,
    output logic dec_store
);
    verdict_t q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q.valid <= frm_valid;
            q.store <= frm_valid && fold_verdict(acc_hit, drp_hit);
        end
    end

    assign dec_valid = q.valid;
    assign dec_store = q.store;

endmodule

// File: rtl/ff_frame_filter.sv
module ff_frame_filter
    import ff_pkg::*;
#(
    parameter int ID_W   = FF_ID_W,
    parameter int NUM_CH = FF_NUM_CH,
    parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_wr_en,
    input  logic [2:0]      cfg_wr_sel,
    input  logic [ID_W-1:0] cfg_wr_data,
    input  logic            frm_valid,
    input  logic [ID_W-1:0] frm_id,
    input  logic [CH_W-1:0] frm_chan,
    output logic            dec_valid,
    output logic            dec_store
);
    logic [ID_W-1:0]   acc_pat, acc_mask, drp_pat, drp_mask;
    logic [NUM_CH-1:0] acc_chen, drp_chen;
    logic              acc_hit, drp_hit;

    ff_cfg_regs #(.ID_W(ID_W), .NUM_CH(NUM_CH)) u_regs (
        .clk(clk), .rst(rst),
        .wr_en(cfg_wr_en), .wr_sel(cfg_wr_sel), .wr_data(cfg_wr_data),
        .acc_pat(acc_pat), .acc_mask(acc_mask),
        .drp_pat(drp_pat), .drp_mask(drp_mask),
        .acc_chen(acc_chen), .drp_chen(drp_chen)
    );

    ff_masked_match #(.ID_W(ID_W), .NUM_CH(NUM_CH), .CH_W(CH_W)) u_acc (
        .id(frm_id), .chan(frm_chan), .pat(acc_pat), .mask(acc_mask),
        .chen(acc_chen), .hit(acc_hit)
    );

    ff_masked_match #(.ID_W(ID_W), .NUM_CH(NUM_CH), .CH_W(CH_W)) u_drp (
        .id(frm_id), .chan(frm_chan), .pat(drp_pat), .mask(drp_mask),
        .chen(drp_chen), .hit(drp_hit)
    );

    ff_verdict u_verdict (
        .clk(clk), .rst(rst), .frm_valid(frm_valid),
        .acc_hit(acc_hit), .drp_hit(drp_hit),
        .dec_valid(dec_valid), .dec_store(dec_store)
    );

endmodule

// File: rtl/ff_frame_filter_chk.sv
module ff_frame_filter_chk #(
    parameter int ID_W   = 11,
    parameter int NUM_CH = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_wr_en,
    input logic [2:0]        cfg_wr_sel,
    input logic              frm_valid,
    input logic              acc_hit,
    input logic              drp_hit,
    input logic [ID_W-1:0]   acc_pat,
    input logic [ID_W-1:0]   drp_pat,
    input logic [NUM_CH-1:0] acc_chen,
    input logic [NUM_CH-1:0] drp_chen,
    input logic              dec_valid,
    input logic              dec_store
);
    AST_STORE_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && acc_hit && !drp_hit) |=> dec_store); // R1
    AST_DROP_WINS: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && drp_hit) |=> !dec_store); // R3
    AST_NEED_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && !acc_hit) |=> !dec_store); // R5
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        frm_valid |=> dec_valid); // R7
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
        !frm_valid |=> !dec_valid); // R7
    AST_STORE_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        !dec_valid |-> !dec_store); // R7
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cfg_wr_en |=> ($stable(acc_pat) && $stable(drp_pat) && $stable(acc_chen) && $stable(drp_chen))); // R8
    AST_BAD_SEL_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr_en && cfg_wr_sel > 3'd4) |=> ($stable(acc_pat) && $stable(drp_pat) && $stable(acc_chen) && $stable(drp_chen))); // R10
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!dec_valid && acc_chen == '0 && drp_chen == '0 && acc_pat == '0)); // R9
endmodule

bind ff_frame_filter ff_frame_filter_chk #(.ID_W(ID_W), .NUM_CH(NUM_CH)) u_chk (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
    .frm_valid(frm_valid), .acc_hit(acc_hit), .drp_hit(drp_hit),
    .acc_pat(acc_pat), .drp_pat(drp_pat),
    .acc_chen(acc_chen), .drp_chen(drp_chen),
    .dec_valid(dec_valid), .dec_store(dec_store)
);

// File: tb/sim_ff_frame_filter.sv
`timescale 1ns/1ps
module sim_ff_frame_filter;
    localparam int ID_W   = 11;
    localparam int NUM_CH = 2;
    localparam int CH_W   = 1;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            cfg_wr_en = 1'b0;
    logic [2:0]      cfg_wr_sel = '0;
    logic [ID_W-1:0] cfg_wr_data = '0;
    logic            frm_valid = 1'b0;
    logic [ID_W-1:0] frm_id = '0;
    logic [CH_W-1:0] frm_chan = '0;
    logic            dec_valid, dec_store;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // behavioural reference state
    int m_acc_pat = 0, m_acc_mask = 0, m_drp_pat = 0, m_drp_mask = 0, m_chan = 0;

    always #4 clk = ~clk;

    ff_frame_filter u0 (
        .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
        .cfg_wr_data(cfg_wr_data), .frm_valid(frm_valid), .frm_id(frm_id),
        .frm_chan(frm_chan), .dec_valid(dec_valid), .dec_store(dec_store)
    );

    function automatic bit model_store(int id, int ch);
        bit acc_ok, drp_ok;
        acc_ok = ((m_chan >> ch) & 1) == 1 &&
                 (((id ^ m_acc_pat) & ~m_acc_mask) & ((1 << ID_W) - 1)) == 0;
        drp_ok = ((m_chan >> (NUM_CH + ch)) & 1) == 1 &&
                 (((id ^ m_drp_pat) & ~m_drp_mask) & ((1 << ID_W) - 1)) == 0;
        return acc_ok && !drp_ok;
    endfunction

    task automatic check(string tag, bit act, bit exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // one clock: drive at negedge, compare at the following negedge
    task automatic cyc(bit we, int sel, int data, bit fv, int id, int ch, string tag);
        bit ev, es;
        cfg_wr_en   = we;
        cfg_wr_sel  = sel[2:0];
        cfg_wr_data = data[ID_W-1:0];
        frm_valid   = fv;
        frm_id      = id[ID_W-1:0];
        frm_chan    = ch[CH_W-1:0];
        ev = fv;
        es = fv && model_store(id, ch);
        if (we) begin
            case (sel)
                0: m_acc_pat  = data & ((1 << ID_W) - 1);
                1: m_acc_mask = data & ((1 << ID_W) - 1);
                2: m_drp_pat  = data & ((1 << ID_W) - 1);
                3: m_drp_mask = data & ((1 << ID_W) - 1);
                4: m_chan     = data & ((1 << (2 * NUM_CH)) - 1);
                default: ;
            endcase
        end
        @(negedge clk);
        check(tag, dec_valid, ev, "dec_valid");
        check(tag, dec_store, es, "dec_store");
    endtask

    task automatic wr(int sel, int data, string tag);
        cyc(1, sel, data, 0, 0, 0, tag);
    endtask

    task automatic frame(int id, int ch, string tag);
        cyc(0, 0, 0, 1, id, ch, tag);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9", dec_valid, 1'b0, "dec_valid in reset");
        rst = 1'b0;
        @(negedge clk);
        check("R9", dec_store, 1'b0, "dec_store after reset");
        // R9: zero config stores nothing, even id 0 on either channel
        frame(0, 0, "R9");
        frame(0, 1, "R9");
        // R1: exact accept match on both enabled channels
        wr(0, 'h123, "R1");
        wr(4, 'b0011, "R1");
        frame('h123, 0, "R1");
        frame('h123, 1, "R1");
        frame('h124, 0, "R1");
        // R2: low nibble don't-care
        wr(1, 'h00F, "R2");
        frame('h12A, 0, "R2");
        frame('h133, 0, "R2");
        frame('h323, 1, "R2");
        // R5: acceptance only on channel 0
        wr(4, 'b0001, "R5");
        frame('h125, 1, "R5");
        frame('h125, 0, "R5");
        // R3: drop pattern wins on channel 0
        wr(4, 'b0111, "R3");
        wr(2, 'h12A, "R3");
        frame('h12A, 0, "R3");
        frame('h12B, 0, "R3");
        // R4: drop mask bits 1:0
        wr(3, 'h003, "R4");
        frame('h129, 0, "R4");
        frame('h12C, 0, "R4");
        frame('h13A, 0, "R4");
        // R6: drop enabled only on channel 0, frame on channel 1 stored
        wr(4, 'b0111, "R6");
        frame('h12A, 1, "R6");
        wr(4, 'b1011, "R6");
        frame('h12A, 0, "R6");
        frame('h12A, 1, "R6");
        // R8: write in the same cycle as a frame uses old settings
        wr(4, 'b0011, "R8");
        cyc(1, 0, 'h400, 1, 'h123, 0, "R8");
        frame('h123, 0, "R8");
        frame('h405, 0, "R8");
        // R10: unused select codes leave everything unchanged
        wr(5, 'h7FF, "R10");
        wr(6, 'h7FF, "R10");
        wr(7, 'h000, "R10");
        frame('h405, 0, "R10");
        frame('h405, 1, "R10");
        frame('h12A, 0, "R10");
        // R7: back-to-back and gapped frames
        frame('h401, 0, "R7");
        frame('h402, 1, "R7");
        cyc(0, 0, 0, 0, 0, 0, "R7");
        frame('h403, 0, "R7");
        // random mixed traffic against the model
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 9);
            if (r == 0)
                cyc(1, $urandom_range(0, 7), $urandom_range(0, 2047),
                    $urandom_range(0, 1), $urandom_range(0, 2047), $urandom_range(0, 1), "R1");
            else if (r < 8)
                frame(($urandom_range(0, 1) ? m_acc_pat : m_drp_pat) ^ $urandom_range(0, 15),
                      $urandom_range(0, 1), "R3");
            else
                cyc(0, 0, 0, 0, 0, 0, "R7");
        end
        // R9: reset mid-run clears settings
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_acc_pat = 0; m_acc_mask = 0; m_drp_pat = 0; m_drp_mask = 0; m_chan = 0;
        check("R9", dec_valid, 1'b0, "dec_valid after second reset");
        frame(0, 0, "R9");
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule